// File: doc/BRIEF.md
# Line Clamp Pulse Generator

This block produces one active-low clamp strobe per video line, meant to steer an external analog clamp so that it samples a reference level at a known place in the line. It watches an active-low horizontal sync input. When it sees a falling edge on that input, it waits a programmable number of pixel-clock cycles and then holds its output low for a fixed time. That time is 0.5 microseconds, expressed as a count of pixel-clock cycles (for example 7 cycles at 13.5 MHz).

The delay comes from an 8-bit position value sampled on the sync edge. The width is a cycle count sampled when the strobe starts. An enable input gates only the output pin; the timing runs whether or not the output is enabled. A new sync edge always restarts the sequence.

Top module: `clamp_pulse_gen`

## Requirements
- R1: While reset is applied and after it is released with no sync edge, `clampN` is high.
- R2: A falling edge of `hsyncN` is detected at the first clock edge where `hsyncN` is low after having been high at the previous clock edge. With `linePos` = N (N > 0) at that edge, `clampN` goes low right after the N-th following clock edge.
- R3: With `linePos` = 0 at the detecting edge, `clampN` goes low right after that detecting edge itself.
- R4: Once started, `clampN` stays low for exactly `pulseCycles` clock cycles and then returns high.
- R5: A `pulseCycles` value of zero at the pulse start suppresses the strobe; `clampN` stays high for that line.
- R6: When `clampEn` is 0, `clampN` is high. The enable masks only the output and does not pause or reset the internal timing.
- R7: A falling edge of `hsyncN` that arrives during the wait or during the low phase abandons the current strobe and starts a fresh delay from that edge. When the new delay is 0 and `clampN` was low, `clampN` stays low without a high gap.
- R8: Holding `hsyncN` low, or a rising edge of `hsyncN`, starts no sequence.
- R9: `linePos` is used only at the detecting edge, and `pulseCycles` only at the pulse start. Later changes do not alter a sequence already in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hsyncN | input | 1 | Active-low horizontal sync, synchronous to clk |
| linePos | input | POS_W (8) | Delay in clock cycles from the sync edge to the start of the strobe |
| pulseCycles | input | WID_W (8) | Strobe length in clock cycles; 0 disables the strobe |
| clampEn | input | 1 | Output enable; when low, clampN is forced high |
| clampN | output | 1 | Active-low clamp strobe |

## Verification
The assertions assume that `hsyncN`, `linePos`, `pulseCycles` and `clampEn` are synchronous to the pixel clock and stable around each rising edge. They also assume that the output enable may toggle at any time, which can shorten a visible strobe. The stimulus changes every input only on falling clock edges. It creates sync edges only by driving `hsyncN` high for at least one cycle before driving it low, so every detected edge is a clean single-cycle event. A behavioural reference in the bench tracks the line timing from absolute edge numbers and is compared with `clampN` on every cycle.

// File: rtl/clamp_pulse_pkg.sv
package clamp_pulse_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_PULSE = 2'd2
  } clampState_e;

  // Strobes from the control FSM to the datapath counter
  typedef struct packed {
    logic loadPos;
    logic loadWidth;
    logic dec;
  } cntCtl_t;

endpackage

// File: rtl/clamp_pulse_dp.sv
module clamp_pulse_dp
  import clamp_pulse_pkg::*;
#(
  parameter int POS_W = 8,
  parameter int WID_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hsyncN,
  input  logic [POS_W-1:0] linePos,
  input  logic [WID_W-1:0] pulseCycles,
  input  cntCtl_t          ctl,
  output logic             hsFall,
  output logic             posZero,
  output logic             widthZero,
  output logic             cntOne,
  output logic [CNT_W-1:0] cnt
);

  logic hsyncD;

  // Edge detection against the previous sampled level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hsyncD <= 1'b1;
    else       hsyncD <= hsyncN;
  end

  assign hsFall    = hsyncD & ~hsyncN;
  assign posZero   = (linePos == '0);
  assign widthZero = (pulseCycles == '0);
  assign cntOne    = (cnt == CNT_W'(1));

  // Shared down-counter for both the wait and the low phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (ctl.loadPos)   cnt <= CNT_W'(linePos);
    else if (ctl.loadWidth) cnt <= CNT_W'(pulseCycles);
    else if (ctl.dec)       cnt <= cnt - CNT_W'(1);
  end

endmodule

// File: rtl/clamp_pulse_ctl.sv
module clamp_pulse_ctl
  import clamp_pulse_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    hsFall,
  input  logic    posZero,
  input  logic    widthZero,
  input  logic    cntOne,
  output cntCtl_t ctl,
  output logic    pulseAct
);

  clampState_e state, stateNext;

  always_comb begin
    stateNext     = state;
    ctl           = '0;
    if (hsFall) begin
      // Restart from any state
      if (!posZero) begin
        stateNext   = ST_WAIT;
        ctl.loadPos = 1'b1;
      end else if (!widthZero) begin
        stateNext     = ST_PULSE;
        ctl.loadWidth = 1'b1;
      end else begin
        stateNext = ST_IDLE;
      end
    end else begin
      unique case (state)
        ST_WAIT: begin
          if (cntOne) begin
            if (!widthZero) begin
              stateNext     = ST_PULSE;
              ctl.loadWidth = 1'b1;
            end else begin
              stateNext = ST_IDLE;
            end
          end else begin
            ctl.dec = 1'b1;
          end
        end
        ST_PULSE: begin
          if (cntOne) stateNext = ST_IDLE;
          else        ctl.dec   = 1'b1;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign pulseAct = (state == ST_PULSE);

endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
  import clamp_pulse_pkg::*;
#(
  parameter int POS_W = 8,
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hsyncN,
  input  logic [POS_W-1:0] linePos,
  input  logic [WID_W-1:0] pulseCycles,
  input  logic             clampEn,
  output logic             clampN
);

  localparam int CNT_W = (POS_W > WID_W) ? POS_W : WID_W;

  cntCtl_t          ctl;
  logic             hsFall;
  logic             posZero;
  logic             widthZero;
  logic             cntOne;
  logic             pulseAct;
  logic [CNT_W-1:0] cnt;

  clamp_pulse_dp #(
    .POS_W(POS_W),
    .WID_W(WID_W),
    .CNT_W(CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .hsyncN     (hsyncN),
    .linePos    (linePos),
    .pulseCycles(pulseCycles),
    .ctl        (ctl),
    .hsFall     (hsFall),
    .posZero    (posZero),
    .widthZero  (widthZero),
    .cntOne     (cntOne),
    .cnt        (cnt)
  );

  clamp_pulse_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .hsFall   (hsFall),
    .posZero  (posZero),
    .widthZero(widthZero),
    .cntOne   (cntOne),
    .ctl      (ctl),
    .pulseAct (pulseAct)
  );

  assign clampN = ~(pulseAct & clampEn);

endmodule

// File: rtl/clamp_pulse_chk.sv
module clamp_pulse_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             hsFall,
  input logic             posZero,
  input logic             widthZero,
  input logic             pulseAct,
  input logic             cntOne,
  input logic [CNT_W-1:0] cnt,
  input logic             clampEn,
  input logic             clampN
);

  p_disabled_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    !clampEn |-> clampN);

  p_delay_waits_r2: assert property (@(posedge clk) disable iff (!rstN)
    hsFall && !posZero |=> !pulseAct);

  p_zero_pos_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    hsFall && posZero && !widthZero |=> pulseAct);

  p_zero_width_r5: assert property (@(posedge clk) disable iff (!rstN)
    hsFall && widthZero |=> !pulseAct);

  p_cnt_live_r4: assert property (@(posedge clk) disable iff (!rstN)
    pulseAct |-> cnt != '0);

  p_pulse_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    pulseAct && cntOne && !hsFall |=> !pulseAct);

endmodule

bind clamp_pulse_gen clamp_pulse_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hsFall   (hsFall),
  .posZero  (posZero),
  .widthZero(widthZero),
  .pulseAct (pulseAct),
  .cntOne   (cntOne),
  .cnt      (cnt),
  .clampEn  (clampEn),
  .clampN   (clampN)
);

// File: tb/clamp_pulse_gen_tb.sv
module clamp_pulse_gen_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hsyncN = 1'b1;
  logic [7:0] linePos = 8'd0;
  logic [7:0] pulseCycles = 8'd7;
  logic       clampEn = 1'b1;
  logic       clampN;

  int    tests = 0;
  int    fails = 0;
  int    edgeNo = 0;
  string tag = "R1";

  // Behavioural reference state
  bit mPrevH = 1'b1;
  bit mPending = 1'b0;
  bit mActive = 1'b0;
  int mStart = 0;
  int mEnd = 0;

  always #4 clk = ~clk;

  clamp_pulse_gen u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .hsyncN     (hsyncN),
    .linePos    (linePos),
    .pulseCycles(pulseCycles),
    .clampEn    (clampEn),
    .clampN     (clampN)
  );

  always @(posedge clk) begin
    edgeNo++;
    if (!rstN) begin
      mPrevH = 1'b1; mPending = 1'b0; mActive = 1'b0;
    end else begin
      if (mPrevH && !hsyncN) begin
        mPending = 1'b1;
        mStart   = edgeNo + int'(linePos);
        mActive  = 1'b0;
      end else if (mActive && edgeNo == mEnd) begin
        mActive = 1'b0;
      end
      if (mPending && edgeNo == mStart) begin
        mPending = 1'b0;
        if (pulseCycles != 0) begin
          mActive = 1'b1;
          mEnd    = edgeNo + int'(pulseCycles);
        end
      end
      mPrevH = hsyncN;
    end
    if (edgeNo > 100000) begin
      fails++;
      $display("FAIL watchdog: %s actual=timeout expected=done", tag);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    bit expN;
    expN = rstN ? !(mActive && clampEn) : 1'b1;
    tests++;
    if (clampN !== expN) begin
      fails++;
      $display("FAIL %s at edge %0d: clampN actual=%b expected=%b", tag, edgeNo, clampN, expN);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic syncPulse(input int lowLen);
    hsyncN = 1'b0;
    idle(lowLen);
    hsyncN = 1'b1;
  endtask

  initial begin
    tag = "R1";
    idle(3);
    rstN = 1'b1;
    idle(5);

    tag = "R2";
    linePos = 8'd5; pulseCycles = 8'd7;
    syncPulse(3); idle(30);
    linePos = 8'd1; syncPulse(2); idle(20);

    tag = "R3";
    linePos = 8'd0; pulseCycles = 8'd4;
    syncPulse(1); idle(15);

    tag = "R4";
    linePos = 8'd2;
    pulseCycles = 8'd1;   syncPulse(1); idle(10);
    pulseCycles = 8'd7;   syncPulse(1); idle(15);
    pulseCycles = 8'd200; syncPulse(1); idle(210);

    tag = "R5";
    pulseCycles = 8'd0;
    linePos = 8'd3; syncPulse(1); idle(12);
    linePos = 8'd0; syncPulse(1); idle(12);

    tag = "R6";
    linePos = 8'd2; pulseCycles = 8'd8;
    clampEn = 1'b0; syncPulse(1); idle(15);
    syncPulse(1); idle(4); clampEn = 1'b1; idle(12);
    clampEn = 1'b0; idle(2); clampEn = 1'b1; idle(2);

    tag = "R7";
    linePos = 8'd6; pulseCycles = 8'd5;
    syncPulse(1); idle(3); syncPulse(1); idle(20);
    linePos = 8'd1; pulseCycles = 8'd10;
    syncPulse(1); idle(4); syncPulse(1); idle(20);
    linePos = 8'd0; pulseCycles = 8'd6;
    syncPulse(1); idle(3); syncPulse(1); idle(12);

    tag = "R8";
    linePos = 8'd2; pulseCycles = 8'd3;
    syncPulse(40); idle(20);

    tag = "R9";
    linePos = 8'd4; pulseCycles = 8'd6;
    syncPulse(1); linePos = 8'd20; idle(2); pulseCycles = 8'd1; idle(2);
    pulseCycles = 8'd30; idle(20);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule